// File: doc/BRIEF.md
# Instrument Status Reporting Register Unit

This block is the status core of a remotely controlled test instrument, organised along the IEEE 488.2 status model. A sticky event register collects error and completion events. An 8-bit event enable mask selects which of these events feed an event summary bit. That bit joins the test-result flags and a message-available flag in a status byte. A second 8-bit service-request enable mask reduces the status byte to a master summary bit, and that bit drives the service-request output.

A command decoder in front of the block turns remote commands into one-cycle strobes and supplies an 8-bit write data bus. The decoder reads the event register and the masks through dedicated output buses. The block also keeps track of operation-complete requests, both the form that sets an event bit and the query form that answers 1. The active-low reset models power-up. At power-up a power-on-clear flag, preloaded together with both masks from non-volatile inputs, decides whether the masks are zeroed or take the stored values.

Top module: `instr_status_core`

## Requirements
- R1: At power-up (rst_n low) the event register reads 0x80 and the power-on-clear flag takes nv_pon_clr_i. Both masks take 0x00 when nv_pon_clr_i is 1, and take nv_evt_mask_i and nv_srq_mask_i when it is 0.
- R2: An error pulse sets its event bit one cycle later: qry_err_i sets bit 2, dev_err_i bit 3, exe_err_i bit 4, cmd_err_i bit 5. Set bits stay set while no read or clear occurs. Bits 1 and 6 always read 0.
- R3: evt_q_o shows the event register during an evt_rd_i strobe, and the register is 0 in the next cycle. An event pulsed in the same cycle as the read is kept.
- R4: cls_i zeroes the event register, which drops status bit 5, and leaves both masks unchanged. An event pulsed in the same cycle as cls_i is kept.
- R5: A write strobe (evt_mask_wr_i or srq_mask_wr_i) stores any value 0 to 255 from wdata_i, and that value reads back. Without a strobe the mask holds its value.
- R6: Status bit 5 is 1 exactly when the event register ANDed with the event enable mask is nonzero.
- R7: Status bit 6 is the OR of status bits 0 to 5 and 7, each ANDed with the matching service-request mask bit. Mask bit 6 has no effect. srq_o equals status bit 6.
- R8: The status byte is combinational, and reading it clears nothing. Its inputs map as follows: pass_i to bit 0, fail_i to bit 1, abort_i to bit 2, busy_i to bit 3, mav_i to bit 4, prompt_i to bit 7.
- R9: After opc_req_i, event bit 0 becomes 1 in the cycle after the next op_done_i pulse, and not before.
- R10: After opc_qry_i, opc_ack_o is high for exactly one cycle, the cycle after the next op_done_i pulse.
- R11: rst_cmd_i cancels pending operation-complete requests. It leaves the masks, the power-on-clear flag, the event register and the status byte inputs untouched.
- R12: pcf_wr_i stores wdata_i[0] into the power-on-clear flag, which reads on pcf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low power-up reset |
| nv_pon_clr_i | input | 1 | stored power-on-clear flag |
| nv_evt_mask_i | input | 8 | stored event enable mask |
| nv_srq_mask_i | input | 8 | stored service-request mask |
| wdata_i | input | 8 | write data |
| evt_mask_wr_i | input | 1 | event mask write strobe |
| srq_mask_wr_i | input | 1 | service-request mask write strobe |
| pcf_wr_i | input | 1 | power-on-clear flag write strobe |
| evt_rd_i | input | 1 | event register read strobe (clears the register) |
| cls_i | input | 1 | clear-status strobe |
| rst_cmd_i | input | 1 | reset command strobe |
| opc_req_i | input | 1 | operation-complete request (sets event bit) |
| opc_qry_i | input | 1 | operation-complete query |
| op_done_i | input | 1 | pending operation finished |
| qry_err_i | input | 1 | query error pulse |
| dev_err_i | input | 1 | device error pulse |
| exe_err_i | input | 1 | execution error pulse |
| cmd_err_i | input | 1 | command error pulse |
| pass_i | input | 1 | all tests passed |
| fail_i | input | 1 | test failed |
| abort_i | input | 1 | test aborted |
| busy_i | input | 1 | test in process |
| mav_i | input | 1 | message available |
| prompt_i | input | 1 | prompt state |
| evt_q_o | output | 8 | event register value |
| evt_mask_o | output | 8 | event enable mask |
| srq_mask_o | output | 8 | service-request enable mask |
| pcf_o | output | 1 | power-on-clear flag |
| status_o | output | 8 | status byte |
| srq_o | output | 1 | service request |
| opc_ack_o | output | 1 | operation-complete query answer |

## Verification
Two things can meet in a single cycle: the clearing of the event register, by a read strobe or by clear-status, and the arrival of a new event pulse. The bench pulses exe_err_i together with evt_rd_i, then cmd_err_i together with cls_i. One cycle later the register must hold only the new bit and none of the old ones. A reset command issued while operation-complete requests are pending is another collision. It is judged by pulsing op_done_i afterwards and expecting neither event bit 0 nor an answer pulse.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int SW = 8;

  localparam int EV_OPC = 0;
  localparam int EV_QRY = 2;
  localparam int EV_DEV = 3;
  localparam int EV_EXE = 4;
  localparam int EV_CMD = 5;
  localparam int EV_PON = 7;

  localparam logic [SW-1:0] EV_VALID = 8'hBD;
  localparam logic [SW-1:0] EV_PON_VAL = 8'h80;

  localparam int SB_ESB = 5;
  localparam int SB_MSS = 6;

  function automatic logic esb_calc(input logic [SW-1:0] ev, input logic [SW-1:0] en);
    return |(ev & en);
  endfunction

  function automatic logic mss_calc(input logic [SW-1:0] sb, input logic [SW-1:0] en);
    logic [SW-1:0] keep;
    keep = sb & en;
    keep[SB_MSS] = 1'b0;
    return |keep;
  endfunction
endpackage

// File: rtl/stat_mask_reg.sv
module stat_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pon_clr_i,
  input  logic [W-1:0] nv_val_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= pon_clr_i ? '0 : nv_val_i;
    else if (wr_i) val_q <= wdata_i;
  end

  assign val_o = val_q;

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(val_q));
  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (val_q == $past(wdata_i)));
endmodule

// File: rtl/stat_event_reg.sv
module stat_event_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] VALID = '1,
  parameter logic [W-1:0] PON_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_clr_i,
  input  logic         cls_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] set_ok;
  logic         wipe;

  assign set_ok = set_i & VALID;
  assign wipe   = rd_clr_i | cls_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= PON_VAL;
    else        q <= (wipe ? '0 : q) | set_ok;
  end

  assign q_o = q;

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wipe |=> ((q & $past(q)) == $past(q)));
  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && set_ok == '0) |=> (q == '0));
  p_cls_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i && set_ok == '0) |=> (q == '0));
  p_new_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe && set_ok != '0) |=> (q == $past(set_ok)));
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~VALID) == '0);
endmodule

// File: rtl/stat_opc_track.sv
module stat_opc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic qry_i,
  input  logic done_i,
  input  logic cancel_i,
  output logic evt_fire_o,
  output logic ack_o
);
  logic arm_evt_q, arm_qry_q, ack_q;
  logic arm_evt, arm_qry, qry_fire;

  assign arm_evt    = arm_evt_q | req_i;
  assign arm_qry    = arm_qry_q | qry_i;
  assign evt_fire_o = done_i & arm_evt & ~cancel_i;
  assign qry_fire   = done_i & arm_qry & ~cancel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_evt_q <= 1'b0;
      arm_qry_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      arm_evt_q <= cancel_i ? 1'b0 : (arm_evt & ~done_i);
      arm_qry_q <= cancel_i ? 1'b0 : (arm_qry & ~done_i);
      ack_q     <= qry_fire;
    end
  end

  assign ack_o = ack_q;

  p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  p_no_fire_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_evt_q && !req_i) |-> !evt_fire_o);
  p_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> (!arm_evt_q && !arm_qry_q && !ack_q));
endmodule

// File: rtl/instr_status_core.sv
module instr_status_core
  import stat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_pon_clr_i,
  input  logic [SW-1:0] nv_evt_mask_i,
  input  logic [SW-1:0] nv_srq_mask_i,
  input  logic [SW-1:0] wdata_i,
  input  logic          evt_mask_wr_i,
  input  logic          srq_mask_wr_i,
  input  logic          pcf_wr_i,
  input  logic          evt_rd_i,
  input  logic          cls_i,
  input  logic          rst_cmd_i,
  input  logic          opc_req_i,
  input  logic          opc_qry_i,
  input  logic          op_done_i,
  input  logic          qry_err_i,
  input  logic          dev_err_i,
  input  logic          exe_err_i,
  input  logic          cmd_err_i,
  input  logic          pass_i,
  input  logic          fail_i,
  input  logic          abort_i,
  input  logic          busy_i,
  input  logic          mav_i,
  input  logic          prompt_i,
  output logic [SW-1:0] evt_q_o,
  output logic [SW-1:0] evt_mask_o,
  output logic [SW-1:0] srq_mask_o,
  output logic          pcf_o,
  output logic [SW-1:0] status_o,
  output logic          srq_o,
  output logic          opc_ack_o
);
  logic          opc_fire;
  logic [SW-1:0] evt_set;
  logic [SW-1:0] evt_q;
  logic [SW-1:0] evt_mask, srq_mask;
  logic          pcf_q;
  logic          esb, mss;
  logic [SW-1:0] sb;

  stat_opc_track u_opc (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (opc_req_i),
    .qry_i      (opc_qry_i),
    .done_i     (op_done_i),
    .cancel_i   (rst_cmd_i),
    .evt_fire_o (opc_fire),
    .ack_o      (opc_ack_o)
  );

  always_comb begin
    evt_set         = '0;
    evt_set[EV_OPC] = opc_fire;
    evt_set[EV_QRY] = qry_err_i;
    evt_set[EV_DEV] = dev_err_i;
    evt_set[EV_EXE] = exe_err_i;
    evt_set[EV_CMD] = cmd_err_i;
  end

  stat_event_reg #(.W(SW), .VALID(EV_VALID), .PON_VAL(EV_PON_VAL)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_set),
    .rd_clr_i (evt_rd_i),
    .cls_i    (cls_i),
    .q_o      (evt_q)
  );

  stat_mask_reg #(.W(SW)) u_evt_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .pon_clr_i (nv_pon_clr_i),
    .nv_val_i  (nv_evt_mask_i),
    .wr_i      (evt_mask_wr_i),
    .wdata_i   (wdata_i),
    .val_o     (evt_mask)
  );

  stat_mask_reg #(.W(SW)) u_srq_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .pon_clr_i (nv_pon_clr_i),
    .nv_val_i  (nv_srq_mask_i),
    .wr_i      (srq_mask_wr_i),
    .wdata_i   (wdata_i),
    .val_o     (srq_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcf_q <= nv_pon_clr_i;
    else if (pcf_wr_i) pcf_q <= wdata_i[0];
  end

  assign esb = esb_calc(evt_q, evt_mask);

  always_comb begin
    sb         = {prompt_i, 1'b0, esb, mav_i, busy_i, abort_i, fail_i, pass_i};
    mss        = mss_calc(sb, srq_mask);
    sb[SB_MSS] = mss;
  end

  assign evt_q_o    = evt_q;
  assign evt_mask_o = evt_mask;
  assign srq_mask_o = srq_mask;
  assign pcf_o      = pcf_q;
  assign status_o   = sb;
  assign srq_o      = mss;

  p_esb_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i && evt_set == '0) |=> !status_o[SB_ESB]);
  p_rst_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cmd_i && !evt_mask_wr_i && !srq_mask_wr_i && !pcf_wr_i)
      |=> ($stable(evt_mask) && $stable(srq_mask) && $stable(pcf_q)));
  p_cls_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i && !evt_mask_wr_i && !srq_mask_wr_i) |=> ($stable(evt_mask) && $stable(srq_mask)));
  p_flag_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pcf_wr_i |=> (pcf_q == $past(wdata_i[0])));
endmodule

// File: tb/sim_instr_status_core.sv
module sim_instr_status_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nv_pon_clr = 1'b0;
  logic [7:0] nv_evt = 8'hA5, nv_srq = 8'h3C, wdata = 8'h00;
  logic evt_mask_wr = 0, srq_mask_wr = 0, pcf_wr = 0, evt_rd = 0, cls = 0, rst_cmd = 0;
  logic opc_req = 0, opc_qry = 0, op_done = 0;
  logic qry_err = 0, dev_err = 0, exe_err = 0, cmd_err = 0;
  logic pass = 0, fail = 0, abort_s = 0, busy = 0, mav = 0, prompt = 0;
  logic [7:0] evt_q, evt_mask, srq_mask, status;
  logic pcf, srq, opc_ack;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  instr_status_core u0 (
    .clk(clk), .rst_n(rst_n), .nv_pon_clr_i(nv_pon_clr), .nv_evt_mask_i(nv_evt),
    .nv_srq_mask_i(nv_srq), .wdata_i(wdata), .evt_mask_wr_i(evt_mask_wr),
    .srq_mask_wr_i(srq_mask_wr), .pcf_wr_i(pcf_wr), .evt_rd_i(evt_rd), .cls_i(cls),
    .rst_cmd_i(rst_cmd), .opc_req_i(opc_req), .opc_qry_i(opc_qry), .op_done_i(op_done),
    .qry_err_i(qry_err), .dev_err_i(dev_err), .exe_err_i(exe_err), .cmd_err_i(cmd_err),
    .pass_i(pass), .fail_i(fail), .abort_i(abort_s), .busy_i(busy), .mav_i(mav),
    .prompt_i(prompt), .evt_q_o(evt_q), .evt_mask_o(evt_mask), .srq_mask_o(srq_mask),
    .pcf_o(pcf), .status_o(status), .srq_o(srq), .opc_ack_o(opc_ack)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Expected status byte, restated from R6..R8 with a different formulation
  function automatic logic [7:0] exp_sb(input logic [7:0] ev, input logic [7:0] ee,
                                        input logic [7:0] se);
    logic [7:0] b;
    logic e5, m6;
    e5 = 1'b0;
    for (int i = 0; i < 8; i++) if (ev[i] && ee[i]) e5 = 1'b1;
    b = {prompt, 1'b0, e5, mav, busy, abort_s, fail, pass};
    m6 = 1'b0;
    for (int i = 0; i < 8; i++) if (i != 6 && b[i] && se[i]) m6 = 1'b1;
    b[6] = m6;
    return b;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic power_up(input logic clr);
    nv_pon_clr = clr;
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr_mask(input bit which_srq, input logic [7:0] v);
    wdata = v;
    if (which_srq) srq_mask_wr = 1; else evt_mask_wr = 1;
    step();
    srq_mask_wr = 0; evt_mask_wr = 0;
  endtask

  task automatic read_evt();
    evt_rd = 1; step(); evt_rd = 0;
  endtask

  task automatic t_powerup();
    power_up(1'b0);
    check("R1 esr", evt_q, 8'h80);
    check("R1 ese preload", evt_mask, 8'hA5);
    check("R1 sre preload", srq_mask, 8'h3C);
    check("R1 flag", {7'b0, pcf}, 8'h00);
    power_up(1'b1);
    check("R1 ese zeroed", evt_mask, 8'h00);
    check("R1 sre zeroed", srq_mask, 8'h00);
    check("R1 flag set", {7'b0, pcf}, 8'h01);
  endtask

  task automatic t_events();
    read_evt();
    check("R3 cleared", evt_q, 8'h00);
    qry_err = 1; step(); qry_err = 0;
    check("R2 qry bit2", evt_q, 8'h04);
    dev_err = 1; step(); dev_err = 0;
    cmd_err = 1; step(); cmd_err = 0;
    step(); step();
    check("R2 sticky 2/3/5", evt_q, 8'h2C);
    check("R2 bits1,6 zero", evt_q & 8'h42, 8'h00);
    exe_err = 1; step(); exe_err = 0;
    check("R2 exe bit4", evt_q, 8'h3C);
  endtask

  task automatic t_read_clear();
    evt_rd = 1;
    #1 check("R3 value during read", evt_q, 8'h3C);
    step(); evt_rd = 0;
    check("R3 zero after read", evt_q, 8'h00);
    dev_err = 1; step(); dev_err = 0;
    evt_rd = 1; exe_err = 1; step(); evt_rd = 0; exe_err = 0;
    check("R3 new event kept", evt_q, 8'h10);
  endtask

  task automatic t_cls();
    wr_mask(0, 8'hFF); wr_mask(1, 8'h20);
    check("R6 esb set", status, exp_sb(8'h10, 8'hFF, 8'h20));
    cls = 1; step(); cls = 0;
    check("R4 esr zero", evt_q, 8'h00);
    check("R4 esb dropped", status & 8'h20, 8'h00);
    check("R4 ese kept", evt_mask, 8'hFF);
    check("R4 sre kept", srq_mask, 8'h20);
    qry_err = 1; step(); qry_err = 0;
    cls = 1; cmd_err = 1; step(); cls = 0; cmd_err = 0;
    check("R4 coincident event kept", evt_q, 8'h20);
  endtask

  task automatic t_masks();
    wr_mask(0, 8'h00);
    check("R5 ese 00", evt_mask, 8'h00);
    wr_mask(1, 8'hFF);
    check("R5 sre FF", srq_mask, 8'hFF);
    step(); step();
    check("R5 hold", evt_mask, 8'h00);
    wr_mask(0, 8'h5A);
    check("R5 ese 5A", evt_mask, 8'h5A);
  endtask

  task automatic t_esb_mss();
    read_evt();
    qry_err = 1; step(); qry_err = 0;
    wr_mask(0, 8'h04); wr_mask(1, 8'h00);
    check("R6 esb on", status, exp_sb(8'h04, 8'h04, 8'h00));
    wr_mask(0, 8'h08);
    check("R6 esb off", status, exp_sb(8'h04, 8'h08, 8'h00));
    wr_mask(0, 8'h04); wr_mask(1, 8'h40);
    check("R7 mask bit6 ignored", {7'b0, srq}, 8'h00);
    wr_mask(1, 8'h20);
    check("R7 srq via esb", {7'b0, srq}, 8'h01);
    check("R7 status", status, exp_sb(8'h04, 8'h04, 8'h20));
    wr_mask(1, 8'h01); pass = 1; #1;
    check("R7 srq via pass", {7'b0, srq}, 8'h01);
    pass = 0; prompt = 1; wr_mask(1, 8'h80);
    check("R7 srq via prompt", {7'b0, srq}, 8'h01);
    prompt = 0; #1;
    check("R7 srq low", {7'b0, srq}, 8'h00);
  endtask

  task automatic t_status();
    wr_mask(1, 8'h00); read_evt();
    pass = 1; fail = 0; abort_s = 1; busy = 0; mav = 1; prompt = 0; #1;
    check("R8 pattern A", status, 8'h15);
    pass = 0; fail = 1; abort_s = 0; busy = 1; mav = 0; prompt = 1; #1;
    check("R8 pattern B", status, 8'h8A);
    step(); step();
    check("R8 no clear", status, 8'h8A);
    fail = 0; busy = 0; prompt = 0;
  endtask

  task automatic t_opc();
    opc_req = 1; opc_qry = 1; step(); opc_req = 0; opc_qry = 0;
    step(); step();
    check("R9 not before done", evt_q & 8'h01, 8'h00);
    check("R10 no early ack", {7'b0, opc_ack}, 8'h00);
    op_done = 1; step(); op_done = 0;
    check("R9 bit0 set", evt_q & 8'h01, 8'h01);
    check("R10 ack high", {7'b0, opc_ack}, 8'h01);
    step();
    check("R10 ack one cycle", {7'b0, opc_ack}, 8'h00);
  endtask

  task automatic t_rst();
    read_evt();
    wr_mask(0, 8'h33); wr_mask(1, 8'h11);
    wdata = 8'h01; pcf_wr = 1; step(); pcf_wr = 0;
    check("R12 flag write", {7'b0, pcf}, 8'h01);
    dev_err = 1; step(); dev_err = 0;
    opc_req = 1; opc_qry = 1; step(); opc_req = 0; opc_qry = 0;
    mav = 1;
    rst_cmd = 1; step(); rst_cmd = 0;
    op_done = 1; step(); op_done = 0;
    check("R11 opc cancelled", evt_q, 8'h08);
    check("R11 no ack", {7'b0, opc_ack}, 8'h00);
    check("R11 ese kept", evt_mask, 8'h33);
    check("R11 sre kept", srq_mask, 8'h11);
    check("R11 flag kept", {7'b0, pcf}, 8'h01);
    check("R11 mav kept", status & 8'h10, 8'h10);
    mav = 0;
    wdata = 8'h00; pcf_wr = 1; step(); pcf_wr = 0;
    check("R12 flag clear", {7'b0, pcf}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_powerup();
    t_events();
    t_read_clear();
    t_cls();
    t_masks();
    t_esb_mss();
    t_status();
    t_opc();
    t_rst();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule